// File: doc/BRIEF.md
# 2D Drawing Command Register File

This block is the software-facing front end of a 2D drawing engine. It holds three independent parameter sets, one each for block transfers, line drawing and polygon drawing. Each set stores a command word, source and destination base addresses, a packed size register and packed source and destination coordinate registers. The fields of the command word are decoded for the drawing datapath. The block also provides a fixed idle status word and a sub-control write that latches interrupt enables.

A command starts in one of two ways. If the auto-execute bit (command bit 0) is clear, the command starts when the command word is written. If the bit is set, the command is armed, and every later write to that set's destination coordinate register starts it. Writing the NOP operation code stores the command with auto-execute cleared and starts nothing. A start is a one-clock pulse. While the pulse is high, and until the next start, the parameter and decoded-field outputs show the set that fired. The drawing datapath itself lies outside this block.

Bus access uses 12-bit byte addresses. Bits 11:10 select the set: 1 selects block transfer, 2 selects line and 3 selects polygon. Bits 9:0 select the register within the set:

| Offset | Register |
|---|---|
| 0x0D4 | source base |
| 0x0D8 | destination base |
| 0x100 | command |
| 0x104 | size |
| 0x108 | source XY |
| 0x10C | destination XY |

Address 0x000 is the status register for reads and the sub-control register for writes. Read data is registered and appears one cycle after the read strobe.

Top module: `blit_cmd_regfile`

## Requirements
- R1: After reset, every stored register reads 0, start_o is low and irq_en_o is 0.
- R2: A command write that has bit 0 clear and an operation code other than 1111 raises start_o for exactly one clock, in the cycle after the write, with start_set_o naming the written set.
- R3: A command write with bit 0 set and a non-NOP code starts nothing. Each later write to that set's destination XY register (offset 0x10C) raises start_o for one clock. With bit 0 clear, a destination XY write starts nothing.
- R4: A command write whose bits 30:27 are 1111 (NOP) starts nothing and stores the word with bit 0 cleared, so a later destination XY write to that set starts nothing.
- R5: The size register keeps height in bits 9:0 and width in bits 25:16. Source XY and destination XY keep Y in bits 9:0 and X in bits 25:16. All other bits are discarded and read back as 0.
- R6: Decoding uses bits 30:27 as op_o, bits 24:17 as rop_o, bit 25 as x_pos_o and bit 26 as y_pos_o. Bits 4:2 give bpp_o: format 0 gives 1, format 1 gives 2, format 2 gives 3, and any other format gives 0.
- R7: Address bits 11:10 select the set (1 = block transfer, 2 = line, 3 = polygon). A write to one set leaves the other sets unchanged.
- R8: A read of any address that maps to no register returns 0xFFFFFFFF. This includes set code 0 other than 0x000, unused offsets and misaligned addresses.
- R9: A read of 0x000 returns 0x00003000. A write to 0x000 latches data bits 13:7 into irq_en_o[6:0] and ignores all other bits.
- R10: Read data appears on rdata_o in the cycle after rd_en_i. Source and destination bases keep and return all 32 bits.
- R11: The parameter outputs and decoded fields show the set that last started, both during the start pulse and after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| addr_i | input | 12 | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| irq_en_o | output | 7 | Latched interrupt enables |
| start_o | output | 1 | One-clock command start |
| start_set_o | output | 2 | Set shown on the outputs (0 = block transfer, 1 = line, 2 = polygon) |
| op_o | output | 4 | Operation code |
| rop_o | output | 8 | Raster operation |
| x_pos_o | output | 1 | Left-to-right when high |
| y_pos_o | output | 1 | Top-to-bottom when high |
| bpp_o | output | 2 | Bytes per destination pixel, 0 if reserved |
| src_base_o | output | 32 | Source base address |
| dst_base_o | output | 32 | Destination base address |
| width_o | output | 10 | Width |
| height_o | output | 10 | Height |
| src_x_o | output | 10 | Source X |
| src_y_o | output | 10 | Source Y |
| dst_x_o | output | 10 | Destination X |
| dst_y_o | output | 10 | Destination Y |

## Verification
A stale or wrongly routed armed bit shows within one cycle of the next destination XY write: either a start pulse appears where none is due, or an expected pulse is missing. A write steered into the wrong set shows on the next read-back of the neighbouring set's register, or on the parameter outputs as soon as that set fires. Masking or decode faults appear in the first read that follows the write, because every stored field comes back through rdata_o one cycle after the strobe.

// File: rtl/blit_pkg.sv
package blit_pkg;
  localparam int DATA_W   = 32;
  localparam int ADDR_W   = 12;
  localparam int OFS_W    = 10;
  localparam int COORD_W  = 10;
  localparam int NUM_SETS = 3;
  localparam int SET_W    = $clog2(NUM_SETS + 1);
  localparam int OP_W     = 4;
  localparam int ROP_W    = 8;
  localparam int FMT_W    = 3;
  localparam int IRQ_LSB  = 7;
  localparam int IRQ_W    = 7;
  localparam int HI_LSB   = 16;

  localparam int CMD_AUTO    = 0;
  localparam int CMD_FMT_LSB = 2;
  localparam int CMD_ROP_LSB = 17;
  localparam int CMD_XPOS    = 25;
  localparam int CMD_YPOS    = 26;
  localparam int CMD_OP_LSB  = 27;

  localparam logic [DATA_W-1:0] STATUS_IDLE = 32'h0000_3000;
  localparam logic [DATA_W-1:0] UNMAPPED    = '1;

  localparam logic [OFS_W-1:0] OFS_SRC  = 10'h0D4;
  localparam logic [OFS_W-1:0] OFS_DST  = 10'h0D8;
  localparam logic [OFS_W-1:0] OFS_CMD  = 10'h100;
  localparam logic [OFS_W-1:0] OFS_SIZE = 10'h104;
  localparam logic [OFS_W-1:0] OFS_SXY  = 10'h108;
  localparam logic [OFS_W-1:0] OFS_DXY  = 10'h10C;

  localparam logic [OP_W-1:0] OP_BLT  = 4'h0;
  localparam logic [OP_W-1:0] OP_FILL = 4'h2;
  localparam logic [OP_W-1:0] OP_LINE = 4'h3;
  localparam logic [OP_W-1:0] OP_POLY = 4'h5;
  localparam logic [OP_W-1:0] OP_NOP  = 4'hF;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_SRC, SEL_DST, SEL_CMD, SEL_SIZE, SEL_SXY, SEL_DXY
  } reg_sel_e;
endpackage

// File: rtl/blit_addr_dec.sv
module blit_addr_dec
  import blit_pkg::*;
(
  input  logic [ADDR_W-1:0] addr_i,
  output logic              ctrl_hit_o,
  output logic              set_hit_o,
  output logic [SET_W-1:0]  set_o,
  output reg_sel_e          sel_o
);
  logic [SET_W-1:0] code;
  logic [OFS_W-1:0] ofs;

  assign code = addr_i[ADDR_W-1 -: SET_W];
  assign ofs  = addr_i[OFS_W-1:0];

  always_comb begin
    sel_o = SEL_NONE;
    if (code != '0) begin
      case (ofs)
        OFS_SRC:  sel_o = SEL_SRC;
        OFS_DST:  sel_o = SEL_DST;
        OFS_CMD:  sel_o = SEL_CMD;
        OFS_SIZE: sel_o = SEL_SIZE;
        OFS_SXY:  sel_o = SEL_SXY;
        OFS_DXY:  sel_o = SEL_DXY;
        default:  sel_o = SEL_NONE;
      endcase
    end
  end

  assign ctrl_hit_o = (addr_i == '0);
  assign set_hit_o  = (sel_o != SEL_NONE);
  assign set_o      = code - SET_W'(1);
endmodule

// File: rtl/blit_set_regs.sv
module blit_set_regs
  import blit_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  reg_sel_e           sel_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic [DATA_W-1:0]  cmd_o,
  output logic [DATA_W-1:0]  src_base_o,
  output logic [DATA_W-1:0]  dst_base_o,
  output logic [COORD_W-1:0] width_o,
  output logic [COORD_W-1:0] height_o,
  output logic [COORD_W-1:0] src_x_o,
  output logic [COORD_W-1:0] src_y_o,
  output logic [COORD_W-1:0] dst_x_o,
  output logic [COORD_W-1:0] dst_y_o,
  output logic               start_o
);
  localparam logic [DATA_W-1:0] AUTO_MASK = DATA_W'(1) << CMD_AUTO;

  logic wr_nop;
  logic start_d;

  assign wr_nop = (wdata_i[CMD_OP_LSB +: OP_W] == OP_NOP);

  always_comb begin
    start_d = 1'b0;
    if (we_i) begin
      case (sel_i)
        SEL_CMD: start_d = !wr_nop && !wdata_i[CMD_AUTO];
        SEL_DXY: start_d = cmd_o[CMD_AUTO];
        default: start_d = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_o      <= '0;
      src_base_o <= '0;
      dst_base_o <= '0;
      width_o    <= '0;
      height_o   <= '0;
      src_x_o    <= '0;
      src_y_o    <= '0;
      dst_x_o    <= '0;
      dst_y_o    <= '0;
      start_o    <= 1'b0;
    end else begin
      start_o <= start_d;
      if (we_i) begin
        case (sel_i)
          SEL_CMD: cmd_o <= wr_nop ? (wdata_i & ~AUTO_MASK) : wdata_i;
          SEL_SRC: src_base_o <= wdata_i;
          SEL_DST: dst_base_o <= wdata_i;
          SEL_SIZE: begin
            height_o <= wdata_i[COORD_W-1:0];
            width_o  <= wdata_i[HI_LSB +: COORD_W];
          end
          SEL_SXY: begin
            src_y_o <= wdata_i[COORD_W-1:0];
            src_x_o <= wdata_i[HI_LSB +: COORD_W];
          end
          SEL_DXY: begin
            dst_y_o <= wdata_i[COORD_W-1:0];
            dst_x_o <= wdata_i[HI_LSB +: COORD_W];
          end
          default: ;
        endcase
      end
    end
  end

  assert_nop_disarms_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && sel_i == SEL_CMD && wr_nop) |=> (!cmd_o[CMD_AUTO] && !start_o));

  assert_armed_fires_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && sel_i == SEL_DXY && cmd_o[CMD_AUTO]) |=> start_o);

  assert_start_after_write_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> $past(we_i));
endmodule

// File: rtl/blit_cmd_dec.sv
module blit_cmd_dec
  import blit_pkg::*;
(
  input  logic [DATA_W-1:0] cmd_i,
  output logic [OP_W-1:0]   op_o,
  output logic [ROP_W-1:0]  rop_o,
  output logic              x_pos_o,
  output logic              y_pos_o,
  output logic [1:0]        bpp_o
);
  logic [FMT_W-1:0] fmt;
  logic             unused_cmd_bits;

  assign fmt     = cmd_i[CMD_FMT_LSB +: FMT_W];
  assign op_o    = cmd_i[CMD_OP_LSB +: OP_W];
  assign rop_o   = cmd_i[CMD_ROP_LSB +: ROP_W];
  assign x_pos_o = cmd_i[CMD_XPOS];
  assign y_pos_o = cmd_i[CMD_YPOS];
  assign unused_cmd_bits = ^{cmd_i[DATA_W-1], cmd_i[CMD_ROP_LSB-1:CMD_FMT_LSB+FMT_W],
                             cmd_i[CMD_FMT_LSB-1:0]};

  always_comb begin
    case (fmt)
      3'd0:    bpp_o = 2'd1;
      3'd1:    bpp_o = 2'd2;
      3'd2:    bpp_o = 2'd3;
      default: bpp_o = 2'd0;
    endcase
  end
endmodule

// File: rtl/blit_cmd_regfile.sv
module blit_cmd_regfile
  import blit_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic               rd_en_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic [DATA_W-1:0]  rdata_o,
  output logic [IRQ_W-1:0]   irq_en_o,
  output logic               start_o,
  output logic [SET_W-1:0]   start_set_o,
  output logic [OP_W-1:0]    op_o,
  output logic [ROP_W-1:0]   rop_o,
  output logic               x_pos_o,
  output logic               y_pos_o,
  output logic [1:0]         bpp_o,
  output logic [DATA_W-1:0]  src_base_o,
  output logic [DATA_W-1:0]  dst_base_o,
  output logic [COORD_W-1:0] width_o,
  output logic [COORD_W-1:0] height_o,
  output logic [COORD_W-1:0] src_x_o,
  output logic [COORD_W-1:0] src_y_o,
  output logic [COORD_W-1:0] dst_x_o,
  output logic [COORD_W-1:0] dst_y_o
);
  logic             ctrl_hit;
  logic             set_hit;
  logic [SET_W-1:0] set_idx;
  reg_sel_e         sel;

  logic [DATA_W-1:0]  cmd_a      [NUM_SETS];
  logic [DATA_W-1:0]  src_base_a [NUM_SETS];
  logic [DATA_W-1:0]  dst_base_a [NUM_SETS];
  logic [COORD_W-1:0] width_a    [NUM_SETS];
  logic [COORD_W-1:0] height_a   [NUM_SETS];
  logic [COORD_W-1:0] src_x_a    [NUM_SETS];
  logic [COORD_W-1:0] src_y_a    [NUM_SETS];
  logic [COORD_W-1:0] dst_x_a    [NUM_SETS];
  logic [COORD_W-1:0] dst_y_a    [NUM_SETS];
  logic [NUM_SETS-1:0] start_v;

  logic [SET_W-1:0]  idx_q, idx_d;
  logic [DATA_W-1:0] rd_val;

  blit_addr_dec i_addr_dec (
    .addr_i     (addr_i),
    .ctrl_hit_o (ctrl_hit),
    .set_hit_o  (set_hit),
    .set_o      (set_idx),
    .sel_o      (sel)
  );

  for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
    logic we_s;
    assign we_s = wr_en_i && set_hit && (set_idx == SET_W'(s));

    blit_set_regs i_set (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .we_i       (we_s),
      .sel_i      (sel),
      .wdata_i    (wdata_i),
      .cmd_o      (cmd_a[s]),
      .src_base_o (src_base_a[s]),
      .dst_base_o (dst_base_a[s]),
      .width_o    (width_a[s]),
      .height_o   (height_a[s]),
      .src_x_o    (src_x_a[s]),
      .src_y_o    (src_y_a[s]),
      .dst_x_o    (dst_x_a[s]),
      .dst_y_o    (dst_y_a[s]),
      .start_o    (start_v[s])
    );
  end

  // Output view follows the set that fired most recently.
  always_comb begin
    idx_d = idx_q;
    for (int s = 0; s < NUM_SETS; s++) begin
      if (start_v[s]) idx_d = SET_W'(s);
    end
  end

  assign start_o     = |start_v;
  assign start_set_o = idx_d;
  assign src_base_o  = src_base_a[idx_d];
  assign dst_base_o  = dst_base_a[idx_d];
  assign width_o     = width_a[idx_d];
  assign height_o    = height_a[idx_d];
  assign src_x_o     = src_x_a[idx_d];
  assign src_y_o     = src_y_a[idx_d];
  assign dst_x_o     = dst_x_a[idx_d];
  assign dst_y_o     = dst_y_a[idx_d];

  blit_cmd_dec i_cmd_dec (
    .cmd_i   (cmd_a[idx_d]),
    .op_o    (op_o),
    .rop_o   (rop_o),
    .x_pos_o (x_pos_o),
    .y_pos_o (y_pos_o),
    .bpp_o   (bpp_o)
  );

  always_comb begin
    rd_val = UNMAPPED;
    if (ctrl_hit) begin
      rd_val = STATUS_IDLE;
    end else if (set_hit) begin
      rd_val = '0;
      case (sel)
        SEL_CMD: rd_val = cmd_a[set_idx];
        SEL_SRC: rd_val = src_base_a[set_idx];
        SEL_DST: rd_val = dst_base_a[set_idx];
        SEL_SIZE: begin
          rd_val[COORD_W-1:0]          = height_a[set_idx];
          rd_val[HI_LSB +: COORD_W]    = width_a[set_idx];
        end
        SEL_SXY: begin
          rd_val[COORD_W-1:0]          = src_y_a[set_idx];
          rd_val[HI_LSB +: COORD_W]    = src_x_a[set_idx];
        end
        SEL_DXY: begin
          rd_val[COORD_W-1:0]          = dst_y_a[set_idx];
          rd_val[HI_LSB +: COORD_W]    = dst_x_a[set_idx];
        end
        default: rd_val = UNMAPPED;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q    <= '0;
      irq_en_o <= '0;
      rdata_o  <= '0;
    end else begin
      idx_q <= idx_d;
      if (wr_en_i && ctrl_hit) irq_en_o <= wdata_i[IRQ_LSB +: IRQ_W];
      if (rd_en_i) rdata_o <= rd_val;
    end
  end

  assert_unmapped_ones_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && !ctrl_hit && !set_hit) |=> (rdata_o == UNMAPPED));

  assert_status_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && ctrl_hit) |=> (rdata_o == STATUS_IDLE));

  assert_irq_latch_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && ctrl_hit) |=> (irq_en_o == $past(wdata_i[IRQ_LSB +: IRQ_W])));

  assert_single_start_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(start_v));
endmodule

// File: tb/test_blit_cmd_regfile.sv
module test_blit_cmd_regfile;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic        rd_en_i = 1'b0;
  logic [11:0] addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic [6:0]  irq_en_o;
  logic        start_o;
  logic [1:0]  start_set_o;
  logic [3:0]  op_o;
  logic [7:0]  rop_o;
  logic        x_pos_o, y_pos_o;
  logic [1:0]  bpp_o;
  logic [31:0] src_base_o, dst_base_o;
  logic [9:0]  width_o, height_o, src_x_o, src_y_o, dst_x_o, dst_y_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #4 clk_i = ~clk_i;

  blit_cmd_regfile i_blit_cmd_regfile (.*);

  function automatic logic [11:0] ra(input int set, input int ofs);
    return 12'(((set + 1) << 10) | ofs);
  endfunction

  function automatic logic [31:0] mk_cmd(input int op, input int rop, input int xp,
                                         input int yp, input int fmt, input int au);
    return 32'((op << 27) | (yp << 26) | (xp << 25) | (rop << 17) | (fmt << 2) | au);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [11:0] a, input logic [31:0] d,
                        output logic fired, output logic [1:0] fset);
    @(negedge clk_i);
    wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
    fired = start_o;
    fset  = start_set_o;
  endtask

  task automatic bus_rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk_i);
    rd_en_i = 1'b1; addr_i = a;
    @(negedge clk_i);
    rd_en_i = 1'b0;
    d = rdata_o;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 start", 32'(start_o), 0);
    chk("R1 irq", 32'(irq_en_o), 0);
    bus_rd(ra(0, 'h100), d); chk("R1 cmd0", d, 0);
    bus_rd(ra(2, 'h104), d); chk("R1 size2", d, 0);
    bus_rd(ra(1, 'h0D4), d); chk("R1 src1", d, 0);
  endtask

  task automatic t_immediate();
    logic f; logic [1:0] s;
    bus_wr(ra(0, 'h100), mk_cmd(0, 'hCC, 1, 1, 1, 0), f, s);
    chk("R2 fire", 32'(f), 1);
    chk("R2 set", 32'(s), 0);
    chk("R6 op", 32'(op_o), 0);
    chk("R6 rop", 32'(rop_o), 'hCC);
    chk("R6 xpos", 32'(x_pos_o), 1);
    chk("R6 ypos", 32'(y_pos_o), 1);
    chk("R6 bpp16", 32'(bpp_o), 2);
    @(negedge clk_i);
    chk("R2 one cycle", 32'(start_o), 0);
    bus_wr(ra(0, 'h100), mk_cmd(2, 'h5A, 0, 0, 2, 0), f, s);
    chk("R2 fire fill", 32'(f), 1);
    chk("R6 op fill", 32'(op_o), 2);
    chk("R6 xneg", 32'(x_pos_o), 0);
    chk("R6 bpp24", 32'(bpp_o), 3);
    bus_wr(ra(0, 'h100), mk_cmd(0, 0, 0, 0, 5, 0), f, s);
    chk("R6 bpp reserved", 32'(bpp_o), 0);
    bus_wr(ra(0, 'h100), mk_cmd(0, 'h33, 0, 1, 0, 0), f, s);
    chk("R6 bpp8", 32'(bpp_o), 1);
  endtask

  task automatic t_packed();
    logic f; logic [1:0] s; logic [31:0] d;
    bus_wr(ra(0, 'h104), 32'hFFFF_FFFF, f, s);
    chk("R3 size no fire", 32'(f), 0);
    bus_rd(ra(0, 'h104), d); chk("R5 size mask", d, 32'h03FF_03FF);
    bus_wr(ra(0, 'h104), (32'd100 << 16) | 32'd50, f, s);
    bus_wr(ra(0, 'h108), 32'hFC07_0009, f, s);
    bus_rd(ra(0, 'h108), d); chk("R5 sxy mask", d, 32'h0007_0009);
    bus_wr(ra(0, 'h10C), (32'd300 << 16) | 32'd200, f, s);
    chk("R3 dxy unarmed", 32'(f), 0);
    bus_rd(ra(0, 'h10C), d); chk("R5 dxy", d, (32'd300 << 16) | 32'd200);
    bus_wr(ra(0, 'h0D4), 32'hDEAD_BEEF, f, s);
    bus_wr(ra(0, 'h0D8), 32'h1234_5678, f, s);
    bus_rd(ra(0, 'h0D4), d); chk("R10 src base", d, 32'hDEAD_BEEF);
    bus_rd(ra(0, 'h0D8), d); chk("R10 dst base", d, 32'h1234_5678);
    chk("R11 width", 32'(width_o), 100);
    chk("R11 height", 32'(height_o), 50);
    chk("R11 src_x", 32'(src_x_o), 7);
    chk("R11 dst_y", 32'(dst_y_o), 200);
    chk("R11 src base", src_base_o, 32'hDEAD_BEEF);
  endtask

  task automatic t_latency();
    logic [31:0] d;
    @(negedge clk_i);
    rd_en_i = 1'b1; addr_i = ra(0, 'h0D8);
    @(posedge clk_i); #1;
    d = rdata_o;
    @(negedge clk_i);
    rd_en_i = 1'b0;
    chk("R10 one cycle", d, 32'h1234_5678);
  endtask

  task automatic t_auto();
    logic f; logic [1:0] s; logic [31:0] d;
    bus_wr(ra(1, 'h100), mk_cmd(3, 'hF0, 1, 0, 0, 1), f, s);
    chk("R3 armed no fire", 32'(f), 0);
    bus_wr(ra(1, 'h104), 32'h0005_0006, f, s);
    chk("R3 size no fire", 32'(f), 0);
    bus_wr(ra(1, 'h10C), (32'd11 << 16) | 32'd22, f, s);
    chk("R3 dxy fires", 32'(f), 1);
    chk("R7 set line", 32'(s), 1);
    chk("R11 dst_x", 32'(dst_x_o), 11);
    chk("R11 dst_y", 32'(dst_y_o), 22);
    chk("R11 width", 32'(width_o), 5);
    chk("R11 op", 32'(op_o), 3);
    @(negedge clk_i);
    chk("R11 held", 32'(start_set_o), 1);
    bus_wr(ra(1, 'h10C), 32'h0001_0001, f, s);
    chk("R3 refire", 32'(f), 1);
    bus_rd(ra(0, 'h104), d); chk("R7 set0 intact", d, (32'd100 << 16) | 32'd50);
  endtask

  task automatic t_nop();
    logic f; logic [1:0] s; logic [31:0] d;
    bus_wr(ra(2, 'h100), mk_cmd(5, 'h11, 0, 0, 1, 1), f, s);
    chk("R3 poly armed", 32'(f), 0);
    bus_wr(ra(2, 'h100), mk_cmd(15, 'h22, 1, 1, 1, 1), f, s);
    chk("R4 nop no fire", 32'(f), 0);
    bus_rd(ra(2, 'h100), d); chk("R4 nop stored", d, mk_cmd(15, 'h22, 1, 1, 1, 0));
    bus_wr(ra(2, 'h10C), 32'h0002_0003, f, s);
    chk("R4 disarmed", 32'(f), 0);
  endtask

  task automatic t_unmapped();
    logic [31:0] d;
    bus_rd(12'h004, d); chk("R8 code0", d, 32'hFFFF_FFFF);
    bus_rd(12'h104, d); chk("R8 code0 cmd", d, 32'hFFFF_FFFF);
    bus_rd(12'h4D0, d); chk("R8 gap", d, 32'hFFFF_FFFF);
    bus_rd(12'h502, d); chk("R8 misaligned", d, 32'hFFFF_FFFF);
    bus_rd(12'hDFC, d); chk("R8 top", d, 32'hFFFF_FFFF);
  endtask

  task automatic t_ctrl();
    logic f; logic [1:0] s; logic [31:0] d;
    bus_rd(12'h000, d); chk("R9 status", d, 32'h0000_3000);
    bus_wr(12'h000, 32'hFFFF_FFFF, f, s);
    chk("R9 irq all", 32'(irq_en_o), 'h7F);
    bus_rd(12'h000, d); chk("R9 status fixed", d, 32'h0000_3000);
    bus_wr(12'h000, 32'h0000_0080, f, s);
    chk("R9 irq lsb", 32'(irq_en_o), 'h01);
    bus_wr(12'h000, 32'h0000_407F, f, s);
    chk("R9 irq outside", 32'(irq_en_o), 'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_immediate();
    t_packed();
    t_latency();
    t_auto();
    t_nop();
    t_unmapped();
    t_ctrl();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule